// File: doc/BRIEF.md
# Cell Dirty Flag Stability Controller

This block tracks which simulated cells of a time-multiplexed hardware simulator are unstable, and decides when a simulated system cycle has settled. Each cell owns one dirty bit. A dirty bit is cleared when an evaluation of that cell is launched on an evaluation group. It is set again when any input of that cell changes. It is also set at cycle advance when the cell's stored state moved. Each cell input also carries a pending-change bit, which is exposed so the scheduler can see which inputs triggered a re-evaluation.

The system cycle is settled once no dirty bit remains and every evaluation group reports an empty pipeline. The block then emits a one-clock advance pulse and increments the system-cycle count. It restarts its delta-cycle count at 1 and re-marks only the cells whose state changed. The system-cycle count stops at a configured limit and raises a done output; after that, no further advance is issued.

Top module: `cell_settle_ctrl`

## Requirements
- R1: After reset, every bit of `dirty` is 1, every bit of `in_pend` is 0, `sys_cyc` and `delta_cnt` are 1, and `advance` and `done` are 0.
- R2: When `eval_req[g]` is high, the cell whose index is in `eval_idx[g*IDX_W +: IDX_W]` has its `dirty` bit cleared on the next clock. All of that cell's `in_pend` bits are cleared on the same clock. Any number of groups may launch in one clock.
- R3: A high bit `in_chg[c*INS_PER_CELL + j]` (input j of cell c) sets `in_pend` at that bit position and sets `dirty[c]` on the next clock.
- R4: When a set (input change or state re-mark) and a clear for the same cell or input fall in the same clock, the set wins.
- R5: `stable` is high exactly when all `dirty` bits are 0 and all `grp_busy` bits are 0.
- R6: `advance` is high only when `stable` is high, `done` is low, and `advance` was low in the previous clock. It never stays high for two consecutive clocks.
- R7: On an `advance` clock, each cell with `st_chg[c]` high has `dirty[c]` set on the next clock. On that same next clock, `sys_cyc` increments by one.
- R8: `delta_cnt` is 1 on the clock after an advance. On every clock with `stable` low, it increments by one, saturating at its all-ones value. On stable clocks without advance, it holds.
- R9: `done` is high exactly when `sys_cyc` equals `CYC_LIMIT`. While `done` is high, `advance` stays low and `sys_cyc` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_req | input | NUM_GROUPS | Per-group evaluation-start strobe |
| eval_idx | input | NUM_GROUPS*IDX_W | Per-group cell index being launched |
| in_chg | input | NUM_CELLS*INS_PER_CELL | Per-input change events from port memory |
| grp_busy | input | NUM_GROUPS | Per-group pipeline occupied |
| st_chg | input | NUM_CELLS | Per-cell state changed, sampled on advance |
| dirty | output | NUM_CELLS | Per-cell unstable flag |
| in_pend | output | NUM_CELLS*INS_PER_CELL | Per-input pending change flag |
| stable | output | 1 | System cycle settled |
| advance | output | 1 | One-clock system-cycle advance pulse |
| done | output | 1 | System-cycle limit reached |
| delta_cnt | output | DELTA_W | Delta cycles in the current system cycle |
| sys_cyc | output | CYC_W | Current system cycle, starting at 1 |

## Verification
A dirty bit that is wrongly held low makes `stable` and `advance` rise early, in the very clock after the faulty update. It also freezes `delta_cnt` in that clock. A bit that is wrongly held high keeps `stable` low, so `delta_cnt` keeps climbing while the expected value has already restarted. Every per-bit state is visible directly on `dirty` and `in_pend`. Because of this, the bench compares the full vectors every clock, and any divergence shows up within one clock of its cause. Same-clock set/clear collisions, multi-group launches and the saturation at the cycle limit are driven on purpose.

// File: rtl/cell_settle_ctrl.sv
module cell_settle_ctrl #(
  parameter int NUM_CELLS    = 8,
  parameter int INS_PER_CELL = 2,
  parameter int NUM_GROUPS   = 2,
  parameter int CYC_LIMIT    = 16,
  parameter int DELTA_W      = 8,
  localparam int IDX_W   = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
  localparam int NUM_INS = NUM_CELLS * INS_PER_CELL,
  localparam int CYC_W   = $clog2(CYC_LIMIT + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_GROUPS-1:0]       eval_req,
  input  logic [NUM_GROUPS*IDX_W-1:0] eval_idx,
  input  logic [NUM_INS-1:0]          in_chg,
  input  logic [NUM_GROUPS-1:0]       grp_busy,
  input  logic [NUM_CELLS-1:0]        st_chg,
  output logic [NUM_CELLS-1:0]        dirty,
  output logic [NUM_INS-1:0]          in_pend,
  output logic                        stable,
  output logic                        advance,
  output logic                        done,
  output logic [DELTA_W-1:0]          delta_cnt,
  output logic [CYC_W-1:0]            sys_cyc
);

  localparam logic [IDX_W:0] CELLS_V = NUM_CELLS[IDX_W:0];
  localparam logic [CYC_W-1:0] LIMIT_V = CYC_LIMIT[CYC_W-1:0];

  logic [NUM_CELLS-1:0] clr, hit;
  logic [NUM_INS-1:0]   clr_in;
  logic                 adv_q;

  always_comb begin
    clr = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (eval_req[g] && ({1'b0, eval_idx[g*IDX_W +: IDX_W]} < CELLS_V))
        clr[eval_idx[g*IDX_W +: IDX_W]] = 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    assign hit[c] = |in_chg[c*INS_PER_CELL +: INS_PER_CELL];
    assign clr_in[c*INS_PER_CELL +: INS_PER_CELL] = {INS_PER_CELL{clr[c]}};
  end

  assign stable  = ~|dirty & ~|grp_busy;
  assign done    = (sys_cyc == LIMIT_V);
  assign advance = stable & ~adv_q & ~done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirty     <= '1;
      in_pend   <= '0;
      adv_q     <= 1'b0;
      delta_cnt <= DELTA_W'(1);
      sys_cyc   <= CYC_W'(1);
    end else begin
      dirty   <= (dirty & ~clr) | hit | (advance ? st_chg : '0);
      in_pend <= (in_pend & ~clr_in) | in_chg;
      adv_q   <= advance;
      if (advance) begin
        delta_cnt <= DELTA_W'(1);
        sys_cyc   <= sys_cyc + 1'b1;
      end else if (!stable && delta_cnt != '1) begin
        delta_cnt <= delta_cnt + 1'b1;
      end
    end
  end

endmodule

module cell_settle_ctrl_chk #(
  parameter int NUM_CELLS    = 8,
  parameter int INS_PER_CELL = 2,
  parameter int NUM_GROUPS   = 2,
  parameter int CYC_LIMIT    = 16,
  parameter int DELTA_W      = 8,
  localparam int IDX_W   = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
  localparam int NUM_INS = NUM_CELLS * INS_PER_CELL,
  localparam int CYC_W   = $clog2(CYC_LIMIT + 1)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_GROUPS-1:0]       eval_req,
  input logic [NUM_GROUPS*IDX_W-1:0] eval_idx,
  input logic [NUM_INS-1:0]          in_chg,
  input logic [NUM_GROUPS-1:0]       grp_busy,
  input logic [NUM_CELLS-1:0]        st_chg,
  input logic [NUM_CELLS-1:0]        dirty,
  input logic [NUM_INS-1:0]          in_pend,
  input logic                        stable,
  input logic                        advance,
  input logic                        done,
  input logic [DELTA_W-1:0]          delta_cnt,
  input logic [CYC_W-1:0]            sys_cyc
);

  AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) advance |=> !advance); // R6
  AST_DELTA_RESTART: assert property (@(posedge clk) disable iff (!rst_n) advance |=> delta_cnt == DELTA_W'(1)); // R8
  AST_DELTA_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (!stable && delta_cnt != '1) |=> delta_cnt == $past(delta_cnt) + 1'b1); // R8
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> sys_cyc == $past(sys_cyc) + 1'b1); // R7
  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !advance && $stable(sys_cyc))); // R9

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|in_chg[c*INS_PER_CELL +: INS_PER_CELL]) |=> dirty[c]); // R4
    AST_REMARK: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && st_chg[c]) |=> dirty[c]); // R7
  end

endmodule

bind cell_settle_ctrl cell_settle_ctrl_chk #(
  .NUM_CELLS(NUM_CELLS), .INS_PER_CELL(INS_PER_CELL), .NUM_GROUPS(NUM_GROUPS),
  .CYC_LIMIT(CYC_LIMIT), .DELTA_W(DELTA_W)
) chk_i (.*);

// File: tb/cell_settle_ctrl_tb.sv
module cell_settle_ctrl_tb_top;
  localparam int NC = 8, NI = 16, LIM = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  eval_req = '0, grp_busy = '0;
  logic [5:0]  eval_idx = '0;
  logic [15:0] in_chg = '0;
  logic [7:0]  st_chg = '0;
  logic [7:0]  dirty;
  logic [15:0] in_pend;
  logic        stable, advance, done;
  logic [7:0]  delta_cnt;
  logic [4:0]  sys_cyc;

  cell_settle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .eval_req(eval_req), .eval_idx(eval_idx),
    .in_chg(in_chg), .grp_busy(grp_busy), .st_chg(st_chg), .dirty(dirty),
    .in_pend(in_pend), .stable(stable), .advance(advance), .done(done),
    .delta_cnt(delta_cnt), .sys_cyc(sys_cyc));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit finished = 0;

  logic [7:0]  m_dirty;
  logic [15:0] m_pend;
  logic        m_advq;
  int          m_delta, m_cyc;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic check_regs();
    chk("R2/R3/R4/R7 dirty", dirty, m_dirty);
    chk("R2/R3/R4 in_pend", in_pend, m_pend);
    chk("R8 delta_cnt", delta_cnt, m_delta);
    chk("R7/R9 sys_cyc", sys_cyc, m_cyc);
    chk("R9 done", done, m_cyc == LIM);
  endtask

  task automatic step(input logic [1:0] req, input logic [5:0] idx, input logic [15:0] chg,
                      input logic [1:0] busy, input logic [7:0] st);
    logic [7:0]  clr, hit;
    logic [15:0] clr_in;
    logic        e_stable, e_adv;
    eval_req = req; eval_idx = idx; in_chg = chg; grp_busy = busy; st_chg = st;
    #1;
    e_stable = (m_dirty == 0) && (busy == 0);
    e_adv    = e_stable && !m_advq && (m_cyc != LIM);
    chk("R5 stable", stable, e_stable);
    chk("R6 advance", advance, e_adv);
    clr = '0;
    for (int g = 0; g < 2; g++) if (req[g]) clr[idx[g*3 +: 3]] = 1'b1;
    for (int c = 0; c < NC; c++) begin
      hit[c] = |chg[c*2 +: 2];
      clr_in[c*2 +: 2] = {2{clr[c]}};
    end
    m_dirty = (m_dirty & ~clr) | hit | (e_adv ? st : 8'h00);
    m_pend  = (m_pend & ~clr_in) | chg;
    m_advq  = e_adv;
    if (e_adv) begin m_delta = 1; m_cyc = m_cyc + 1; end
    else if (!e_stable && m_delta != 255) m_delta = m_delta + 1;
    @(negedge clk);
    check_regs();
  endtask

  function automatic logic [5:0] lowest_dirty();
    for (int c = 0; c < NC; c++) if (dirty[c]) return {3'd0, 3'(c)};
    return 6'd0;
  endfunction

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_dirty = '1; m_pend = '0; m_advq = 0; m_delta = 1; m_cyc = 1;
    #1;
    // R1: reset values
    check_regs();
    chk("R1 advance", advance, 0);
    chk("R1 dirty all set", dirty, 8'hFF);

    // R2: launch each cell in turn with a busy pipeline
    for (int c = 0; c < NC; c++) step(2'b01, {3'd0, 3'(c)}, 16'h0, 2'b01, 8'h00);
    chk("R2 all cleared", dirty, 8'h00);
    // R5: busy blocks settle
    step(2'b00, 6'd0, 16'h0, 2'b10, 8'h00);
    // R6/R7: settle, advance with re-mark pattern
    step(2'b00, 6'd0, 16'h0, 2'b00, 8'hA5);
    chk("R7 re-mark", dirty, 8'hA5);
    // R2: two groups launch two cells in one clock
    step(2'b11, {3'd2, 3'd0}, 16'h0, 2'b00, 8'h00);
    chk("R2 dual launch", dirty, 8'hA0);
    // R3: input change sets pending and dirty
    step(2'b00, 6'd0, 16'h0102, 2'b00, 8'h00);
    // R4: clear and set on cell 3 collide (input 1 of cell 3 = bit 7)
    step(2'b01, 6'd3, 16'h0080, 2'b00, 8'h00);
    chk("R4 set wins dirty", dirty[3], 1);
    chk("R4 set wins pend", in_pend[7], 1);
    // R2: launching cell 0 clears its pending inputs
    step(2'b01, 6'd0, 16'h0, 2'b00, 8'h00);
    chk("R2 pend cleared", in_pend[1:0], 0);

    // near-exhaustive pseudo-random sweep
    for (int k = 0; k < 600; k++) begin
      logic [15:0] chg;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      chg = (lfsr[3:0] == 0) ? (16'h1 << lfsr[7:4]) : 16'h0;
      if (lfsr[8]) step({lfsr[9], 1'b1}, {lfsr[12:10], lowest_dirty()[2:0]}, chg,
                        (lfsr[15:13] == 0) ? lfsr[1:0] : 2'b00, lfsr[11:4]);
      else         step(2'b00, 6'd0, chg, 2'b00, lfsr[7:0] & lfsr[15:8]);
    end

    // drain to the cycle limit
    for (int k = 0; k < 2000 && !done; k++)
      step(dirty != 0 ? 2'b01 : 2'b00, lowest_dirty(), 16'h0, 2'b00, 8'h01);
    chk("R9 reached limit", sys_cyc, LIM);
    // R9: nothing advances once done
    for (int k = 0; k < 6; k++) step(2'b00, 6'd0, 16'h0, 2'b00, 8'h00);
    chk("R9 advance low", advance, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule